// File: doc/BRIEF.md
# Dual Converter Conversion Sequencer

This block drives two analog-to-digital converter engines (converter 0 and converter 1) through a start/done handshake. Each start pulse carries a channel code, and the block also outputs a sampling-window length decoded from a 4-bit timing code. Each engine answers some time later with a one-cycle done strobe and a 12-bit result. A two-bit coupling mode decides how the engines work together. They can run fully independently, run independently but report one joint completion, be launched together from converter 0's trigger, or form an alternating chain of three or four conversions that reports once at its end.

Results land in a bank of four entries, organised as two slots with one entry per converter. Each entry has a valid flag and an overrun flag, and a read strobe per slot clears both flags of that slot. Per-converter end-of-conversion flags are cleared by writing 1 to them, and they are gated by interrupt enables. Trigger generation lies outside the block. It arrives as per-converter start pulses that already merge the software and hardware sources. The done strobe from an engine is a stream with no back-pressure: the block has no ready signal and accepts every result in the cycle it is strobed, so the engine may never stall.

Top module: `dual_conv_seq`

## Requirements
- R1: Mode 0 (solo): each start[i] launches converter i on its primary code `pri_sel[3i+:3]`, the result goes to entry i (slot 0), and eoc[i] is set on its completion.
- R2: Mode 1 (joint report): the converters are launched independently as in mode 0 and their results go to entries 0 and 1. eoc[0] is set once both have completed, and eoc[1] is never set while this mode holds.
- R3: Mode 2 (paired): start[0] launches both converters in the same cycle on their primary codes, start[1] has no effect, and eoc[0] is set once both have completed.
- R4: Mode 3 (chain), long form: start[0] runs converter 0 on its primary code, then converter 1 on its primary code, then converter 0 on its secondary code, then converter 1 on its secondary code. Only one converter runs at a time. Conversion k is written to entry k, where entry = slot*2 + converter. eoc[0] is set only after the fourth conversion.
- R5: Mode 3 with short_chain=1 stops after the third conversion (entries 0, 1, 2), then sets eoc[0].
- R6: smp_len decodes smp_code as follows: codes 0–7 give 1–8 cycles, codes 8–14 give 16, 32, 64, 128, 256, 512 and 1024 cycles, and code 15 gives 1024 cycles.
- R7: A completed conversion sets its entry's valid bit. A pulse on rd_slot[s] clears the valid bits of entries 2s and 2s+1.
- R8: A write to an entry whose valid bit is still set sets its overrun bit. The slot read clears the overrun bit, and an overrun bit is never set without the valid bit.
- R9: busy[i] rises with the launch and stays high until the conversion (or the whole chain or pair) is complete. A start pulse that arrives while busy is ignored.
- R10: No conversion starts while enable is 0.
- R11: Writing 1 to clr_eoc[i] clears eoc[i], and irq[i] = eoc[i] AND ie[i].
- R12: cv_chan[3i+:3] reports the channel code that converter i is converting, and it holds that code after the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global converter enable |
| mode | input | 2 | Coupling mode 0..3 |
| short_chain | input | 1 | Chain of three instead of four in mode 3 |
| start | input | 2 | Per-converter start pulses |
| pri_sel | input | 6 | Primary channel codes, 3 bits per converter |
| sec_sel | input | 6 | Secondary channel codes, 3 bits per converter |
| smp_code | input | 4 | Sampling-time code |
| ie | input | 2 | Interrupt enables |
| clr_eoc | input | 2 | Write-1-to-clear for end flags |
| rd_slot | input | 2 | Read strobe per result slot |
| cv_start | output | 2 | One-cycle launch pulse to each engine |
| cv_chan | output | 6 | Channel code per engine, also current-channel status |
| smp_len | output | 11 | Sampling window in cycles |
| cv_done | input | 2 | Result strobe from each engine |
| cv_data | input | 24 | Result from each engine, 12 bits each |
| busy | output | 2 | Per-converter busy |
| eoc | output | 2 | End-of-conversion flags |
| irq | output | 2 | Interrupt requests |
| res_data | output | 48 | Four 12-bit result entries |
| res_valid | output | 4 | Valid flag per entry |
| res_ovr | output | 4 | Overrun flag per entry |

## Verification
Cycle-level properties watch these rules on every cycle: a launch occurs only while enabled and never during a conversion in flight, a launch always shows busy, the chain never runs both engines at once, eoc[1] stays quiet outside mode 0, an overrun bit implies a valid bit, and a slot read clears the slot's valid bits. The chain order, the switch from primary to secondary codes, the mapping of chain steps to entries, and the data that lands in each entry are shown only by the bench scenarios. These compare the engine model's launch log and results against expectations. The same applies to the joint completion in modes 1 and 2 and to the decode table for the sampling time.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int NCONV = 2;
  localparam int NSLOT = 2;
  localparam int NENT  = NCONV * NSLOT;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'd0,
    MODE_JOIN  = 2'd1,
    MODE_PAIR  = 2'd2,
    MODE_CHAIN = 2'd3
  } mode_e;
endpackage

// File: rtl/conv_smp_decode.sv
module conv_smp_decode #(
  parameter int CODEW = 4,
  parameter int LENW  = 11
) (
  input  logic [CODEW-1:0] code,
  output logic [LENW-1:0]  len
);
  logic [CODEW-1:0] sh;

  always_comb begin
    sh = (code == '1) ? CODEW'(10) : code - CODEW'(4);
    if (code < CODEW'(8)) len = LENW'(code) + LENW'(1);
    else                  len = LENW'(1) << sh;
  end

  // R6: the window is never empty and never exceeds 1024 cycles
  always_comb begin
    a_len_range_r6: assert (len != '0 && len <= LENW'(1024));
  end
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank #(
  parameter int DW    = 12,
  parameter int NCONV = 2,
  parameter int NSLOT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCONV*NSLOT-1:0]   wr_en,
  input  logic [NCONV*NSLOT*DW-1:0] wr_data,
  input  logic [NSLOT-1:0]         rd_slot,
  output logic [NCONV*NSLOT*DW-1:0] data,
  output logic [NCONV*NSLOT-1:0]   valid,
  output logic [NCONV*NSLOT-1:0]   ovr
);
  localparam int NENT = NCONV * NSLOT;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    localparam int S = g / NCONV;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[g*DW +: DW] <= '0;
        valid[g]         <= 1'b0;
        ovr[g]           <= 1'b0;
      end else if (wr_en[g]) begin
        data[g*DW +: DW] <= wr_data[g*DW +: DW];
        valid[g]         <= 1'b1;
        ovr[g]           <= (ovr[g] | valid[g]) & ~rd_slot[S];
      end else if (rd_slot[S]) begin
        valid[g] <= 1'b0;
        ovr[g]   <= 1'b0;
      end
    end

    p_ovr_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovr[g] |-> valid[g]);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_slot[S]) && !$past(wr_en[g])) |-> !valid[g]);
  end
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic                short_chain,
  input  logic [NCONV-1:0]    start,
  input  logic [NCONV*CW-1:0] pri_sel,
  input  logic [NCONV*CW-1:0] sec_sel,
  input  logic [NCONV-1:0]    cv_done,
  input  logic [NCONV*DW-1:0] cv_data,
  output logic [NCONV-1:0]    cv_start,
  output logic [NCONV*CW-1:0] cv_chan,
  output logic [NCONV-1:0]    busy,
  output logic [NENT-1:0]     wr_en,
  output logic [NENT*DW-1:0]  wr_data,
  output logic [NCONV-1:0]    eoc_set
);
  localparam int STEPW = $clog2(NENT);

  mode_e             md;
  logic [NCONV-1:0]  run, launch_q, seen, go;
  logic [CW-1:0]     chan_q [NCONV];
  logic [STEPW-1:0]  step, nxt_step;
  logic              chain, idle_all, chain_go, chain_done, last, adv, both;

  assign md         = mode_e'(mode);
  assign idle_all   = ~|run & ~chain;
  assign chain_done = chain & cv_done[step[0]];
  assign last       = (step == STEPW'(NENT-1)) | (short_chain & step == STEPW'(NENT-2));
  assign adv        = chain_done & ~last;
  assign nxt_step   = step + STEPW'(1);
  assign both       = &(seen | cv_done);
  assign chain_go   = (md == MODE_CHAIN) & go[0];

  always_comb begin
    unique case (md)
      MODE_SOLO, MODE_JOIN: go = {NCONV{enable}} & start & ~run;
      MODE_PAIR:            go = {NCONV{enable & start[0] & idle_all}};
      default:              go = {1'b0, enable & start[0] & idle_all};
    endcase
  end

  always_comb begin
    unique case (md)
      MODE_SOLO:            eoc_set = cv_done;
      MODE_JOIN, MODE_PAIR: eoc_set = {1'b0, both};
      default:              eoc_set = {1'b0, chain_done & last};
    endcase
  end

  always_comb begin
    wr_en = '0;
    if (chain) wr_en[step] = chain_done;
    else       wr_en[NCONV-1:0] = cv_done;
  end

  for (genvar g = 0; g < NENT; g++) begin : g_wd
    assign wr_data[g*DW +: DW] = cv_data[(g % NCONV)*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= 1'b0;
      step  <= '0;
      seen  <= '0;
    end else begin
      if (chain_go)                chain <= 1'b1;
      else if (chain_done && last) chain <= 1'b0;
      if (chain_go)   step <= '0;
      else if (adv)   step <= nxt_step;
      if (md == MODE_JOIN || md == MODE_PAIR) seen <= both ? '0 : (seen | cv_done);
      else                                    seen <= '0;
    end
  end

  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    logic nxt_mine;
    assign nxt_mine = adv & (nxt_step[0] == 1'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run[i]      <= 1'b0;
        launch_q[i] <= 1'b0;
        chan_q[i]   <= '0;
      end else begin
        run[i]      <= (run[i] & ~cv_done[i]) | go[i] | nxt_mine;
        launch_q[i] <= go[i] | nxt_mine;
        if (go[i])         chan_q[i] <= pri_sel[i*CW +: CW];
        else if (nxt_mine) chan_q[i] <= nxt_step[STEPW-1] ? sec_sel[i*CW +: CW]
                                                          : pri_sel[i*CW +: CW];
      end
    end

    assign cv_chan[i*CW +: CW] = chan_q[i];

    p_launch_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start[i] |-> ($past(enable) || $past(chain)));

    p_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start[i] |-> busy[i]);

    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run[i]) && !$past(cv_done[i])) |-> !cv_start[i]);
  end

  assign cv_start = launch_q;
  assign busy     = run | {NCONV{chain}};

  p_chain_serial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chain |-> !(&run));
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 3,
  parameter int CODEW = 4,
  parameter int LENW  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic                short_chain,
  input  logic [NCONV-1:0]    start,
  input  logic [NCONV*CW-1:0] pri_sel,
  input  logic [NCONV*CW-1:0] sec_sel,
  input  logic [CODEW-1:0]    smp_code,
  input  logic [NCONV-1:0]    ie,
  input  logic [NCONV-1:0]    clr_eoc,
  input  logic [NSLOT-1:0]    rd_slot,
  output logic [NCONV-1:0]    cv_start,
  output logic [NCONV*CW-1:0] cv_chan,
  output logic [LENW-1:0]     smp_len,
  input  logic [NCONV-1:0]    cv_done,
  input  logic [NCONV*DW-1:0] cv_data,
  output logic [NCONV-1:0]    busy,
  output logic [NCONV-1:0]    eoc,
  output logic [NCONV-1:0]    irq,
  output logic [NENT*DW-1:0]  res_data,
  output logic [NENT-1:0]     res_valid,
  output logic [NENT-1:0]     res_ovr
);
  logic [NENT-1:0]    wr_en;
  logic [NENT*DW-1:0] wr_data;
  logic [NCONV-1:0]   eoc_set;

  conv_smp_decode #(.CODEW(CODEW), .LENW(LENW)) u_dec (
    .code(smp_code), .len(smp_len));

  conv_seq_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .short_chain(short_chain), .start(start), .pri_sel(pri_sel),
    .sec_sel(sec_sel), .cv_done(cv_done), .cv_data(cv_data),
    .cv_start(cv_start), .cv_chan(cv_chan), .busy(busy),
    .wr_en(wr_en), .wr_data(wr_data), .eoc_set(eoc_set));

  conv_result_bank #(.DW(DW), .NCONV(NCONV), .NSLOT(NSLOT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_slot(rd_slot), .data(res_data), .valid(res_valid), .ovr(res_ovr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoc <= '0;
    else        eoc <= eoc_set | (eoc & ~clr_eoc);
  end

  assign irq = eoc & ie;

  p_eoc1_solo_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && !eoc[1]) |=> !eoc[1]);

  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_eoc[0]) && !$past(cv_done[0]) && !$past(cv_done[1])) |-> !eoc[0]);
endmodule

// File: tb/dual_conv_seq_bench.sv
module dual_conv_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, short_chain;
  logic [1:0]  mode, start, ie, clr_eoc, rd_slot, cv_start, busy, eoc, irq;
  logic [5:0]  pri_sel, sec_sel, cv_chan;
  logic [3:0]  smp_code, res_valid, res_ovr;
  logic [10:0] smp_len;
  logic [1:0]  cv_done = '0;
  logic [23:0] cv_data = '0;
  logic [47:0] res_data;

  int n_vec = 0, n_bad = 0;
  int m_cnt [2] = '{0, 0};
  logic [11:0] m_pend [2];
  int lg_n = 0, ser = 0;
  int lg_conv [64];
  logic [2:0]  lg_chan [64];
  logic [11:0] lg_data [64];

  always #5 clk = ~clk;

  dual_conv_seq u_dual_conv_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .short_chain(short_chain), .start(start), .pri_sel(pri_sel),
    .sec_sel(sec_sel), .smp_code(smp_code), .ie(ie), .clr_eoc(clr_eoc),
    .rd_slot(rd_slot), .cv_start(cv_start), .cv_chan(cv_chan),
    .smp_len(smp_len), .cv_done(cv_done), .cv_data(cv_data), .busy(busy),
    .eoc(eoc), .irq(irq), .res_data(res_data), .res_valid(res_valid),
    .res_ovr(res_ovr));

  // converter engine model: done after smp_len cycles, result tags channel
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      cv_done[i] <= 1'b0;
      if (cv_start[i]) begin
        m_cnt[i]  = int'(smp_len);
        m_pend[i] = {cv_chan[3*i +: 3], 1'(i), ser[7:0]};
        ser++;
        if (lg_n < 64) begin
          lg_conv[lg_n] = i;
          lg_chan[lg_n] = cv_chan[3*i +: 3];
          lg_data[lg_n] = m_pend[i];
          lg_n++;
        end
      end else if (m_cnt[i] > 0) begin
        m_cnt[i]--;
        if (m_cnt[i] == 0) begin
          cv_done[i] <= 1'b1;
          cv_data[12*i +: 12] <= m_pend[i];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code);
    if (code < 8) return code + 1;
    if (code == 15) return 1024;
    return 16 << (code - 8);
  endfunction

  task automatic clear_all();
    @(negedge clk); rd_slot = 2'b11; clr_eoc = 2'b11;
    @(negedge clk); rd_slot = 2'b00; clr_eoc = 2'b00;
  endtask

  task automatic pulse(input logic [1:0] s);
    @(negedge clk); start = s;
    @(negedge clk); start = 2'b00;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy != 2'b00; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] md, input logic sh, input logic [3:0] code,
                        input logic [5:0] pr, input logic [5:0] se, input logic [1:0] ien);
    string tag;
    int n_exp;
    int e_conv [4];
    logic [2:0] e_chan [4];
    logic [3:0] e_val;
    tag = (md == 2'd0) ? "R1" : (md == 2'd1) ? "R2" : (md == 2'd2) ? "R3" : (sh ? "R5" : "R4");
    @(negedge clk);
    mode = md; short_chain = sh; smp_code = code; pri_sel = pr; sec_sel = se; ie = ien;
    clear_all();
    lg_n = 0;
    pulse(md[1] ? 2'b01 : 2'b11);
    wait_idle();
    if (md != 2'd3) begin
      n_exp = 2; e_conv = '{0, 1, 0, 0}; e_chan = '{pr[2:0], pr[5:3], 3'd0, 3'd0};
      e_val = 4'b0011;
    end else begin
      n_exp = sh ? 3 : 4; e_conv = '{0, 1, 0, 1};
      e_chan = '{pr[2:0], pr[5:3], se[2:0], se[5:3]};
      e_val = sh ? 4'b0111 : 4'b1111;
    end
    chk({tag, " conversion count"}, lg_n, n_exp);
    for (int k = 0; k < n_exp && k < lg_n; k++) begin
      chk({tag, " converter order"}, lg_conv[k], e_conv[k]);
      chk({tag, " channel code"}, lg_chan[k], e_chan[k]);
      chk({tag, " entry data"}, res_data[12*k +: 12], lg_data[k]);
    end
    chk({tag, " R7 valid set"}, res_valid, e_val);
    chk({tag, " end flags"}, eoc, (md == 2'd0) ? 2'b11 : 2'b01);
    chk("R11 irq gating", irq, eoc & ien);
    chk("R12 channel status conv0", cv_chan[2:0], (md == 2'd3) ? se[2:0] : pr[2:0]);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; enable = 1'b1; mode = 2'd0; short_chain = 1'b0; start = '0;
    pri_sel = 6'o21; sec_sel = 6'o43; smp_code = 4'd2; ie = '0; clr_eoc = '0; rd_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset valid", res_valid, 4'b0000);
    chk("R11 reset eoc", eoc, 2'b00);
    chk("R9 reset busy", busy, 2'b00);
    chk("R9 reset launch", cv_start, 2'b00);

    for (int c = 0; c < 16; c++) begin
      smp_code = 4'(c);
      #1 chk("R6 sampling length", smp_len, exp_len(c));
    end

    // directed: each mode, both chain lengths, longest window
    run_op(2'd0, 1'b0, 4'd3, 6'o52, 6'o17, 2'b11);
    run_op(2'd1, 1'b0, 4'd5, 6'o34, 6'o17, 2'b01);
    run_op(2'd2, 1'b0, 4'd1, 6'o16, 6'o25, 2'b10);
    run_op(2'd3, 1'b0, 4'd0, 6'o12, 6'o67, 2'b01);
    run_op(2'd3, 1'b1, 4'd4, 6'o70, 6'o45, 2'b01);
    run_op(2'd0, 1'b0, 4'd15, 6'o07, 6'o00, 2'b00);

    // R3: start[1] alone does nothing in paired mode
    clear_all(); lg_n = 0; mode = 2'd2;
    pulse(2'b10); repeat (20) @(negedge clk);
    chk("R3 start1 ignored count", lg_n, 0);
    chk("R3 start1 ignored valid", res_valid, 4'b0000);

    // R11: write-1-to-clear one flag at a time
    run_op(2'd0, 1'b0, 4'd2, 6'o11, 6'o22, 2'b10);
    @(negedge clk); clr_eoc = 2'b01; @(negedge clk); clr_eoc = 2'b00;
    chk("R11 clear eoc0 only", eoc, 2'b10);
    chk("R11 irq after clear", irq, 2'b10);

    // R8: second result before read -> overrun; read clears slot 0 only
    run_op(2'd0, 1'b0, 4'd2, 6'o11, 6'o22, 2'b00);
    pulse(2'b11); wait_idle();
    chk("R8 overrun set", res_ovr, 4'b0011);
    chk("R8 valid kept", res_valid, 4'b0011);
    @(negedge clk); rd_slot = 2'b01; @(negedge clk); rd_slot = 2'b00;
    chk("R8 overrun cleared by read", res_ovr, 4'b0000);
    chk("R7 valid cleared by read", res_valid, 4'b0000);

    // R9: busy during conversion, start while busy ignored
    clear_all(); lg_n = 0; mode = 2'd0; smp_code = 4'd9;
    pulse(2'b01);
    chk("R9 busy raised", busy, 2'b01);
    repeat (5) @(negedge clk);
    pulse(2'b01); wait_idle();
    chk("R9 restart ignored", lg_n, 1);
    chk("R9 busy dropped", busy, 2'b00);

    // R10: disabled -> no launch
    clear_all(); lg_n = 0; enable = 1'b0; smp_code = 4'd1;
    pulse(2'b11); repeat (40) @(negedge clk);
    chk("R10 no launch when disabled", lg_n, 0);
    chk("R10 no busy when disabled", busy, 2'b00);
    enable = 1'b1;

    // constrained random operations
    for (int t = 0; t < 24; t++) begin
      run_op(2'($urandom % 4), 1'($urandom % 2), 4'($urandom % 10),
             6'($urandom), 6'($urandom), 2'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule